// File: doc/BRIEF.md
# Audio Input Routing and Masking Matrix

This block steers four serial audio data lines and three bit-clock/frame-clock pairs towards two rate converters and the synchronous processor port. A stereo converter (converter 1) and a three-stereo converter (converter 2) can each be given any data line and any clock pair. The synchronous port can pick any clock pair. A data line that an enabled converter claims is hidden from the processor's synchronous inputs. The processor then sees that line as invalid and reads zero on it.

Converter 2 returns three serial channels. Channel A always goes straight to the processor. Channel B can replace data line 2 and channel C can replace data line 3. Each swap has its own enable and is off after reset.

Every configuration field is a request. A per-route state machine applies the request on a frame boundary, which is a falling frame-clock edge of the pair that the route currently uses. This keeps a sample from being split. The machine has three states: ST_IDLE, ST_ARMED and ST_COMMIT. It goes ST_IDLE→ST_ARMED when a valid request differs from the active setting. It goes ST_ARMED→ST_IDLE if the request becomes equal to the active setting again or becomes invalid. It goes ST_ARMED→ST_COMMIT on the frame edge, and loads the request at that edge. It always goes ST_COMMIT→ST_IDLE on the next cycle. All outputs are registered, with one cycle of latency from the inputs.

Top module: `audio_in_router`

## Requirements
- R1: After reset, converter 1 uses pair 0 and converter 2 uses pair 2, and both converters are disabled. The synchronous port uses pair 1, both swaps are off, and proc_valid reads 4'b1111.
- R2: c1_sdata, c1_bclk and c1_lrclk equal, one cycle later, the data line and clock pair in converter 1's active setting.
- R3: c2_sdata, c2_bclk and c2_lrclk equal, one cycle later, the data line and clock pair in converter 2's active setting.
- R4: sp_bclk and sp_lrclk equal, one cycle later, the clock pair in the synchronous port's active setting.
- R5: A line claimed by an enabled converter, and not swapped, shows proc_valid bit 0 and proc_data bit 0. An unclaimed, unswapped line shows valid 1 and its SDIN value, one cycle later.
- R6: When the active swap B bit is set, proc_data bit 2 carries src_ch_b and proc_valid bit 2 is 1, even when line 2 is claimed.
- R7: When the active swap C bit is set, proc_data bit 3 carries src_ch_c and proc_valid bit 3 is 1, even when line 3 is claimed.
- R8: proc_ch_a equals src_ch_a one cycle later, whatever the configuration.
- R9: A changed request takes effect only at a falling edge of the frame clock of the route's active pair. Frame edges on other pairs leave the route unchanged.
- R10: A request that returns to the active setting before a frame edge comes causes no change.
- R11: A request whose pair code is 3 (no such pair) is ignored. The active setting stays unchanged across frame edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; serial lines are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdin | input | 4 | Serial data lines |
| bclk | input | 3 | Bit clocks, one per pair |
| lrclk | input | 3 | Frame clocks, one per pair |
| src_ch_a | input | 1 | Converter 2 output channel A |
| src_ch_b | input | 1 | Converter 2 output channel B |
| src_ch_c | input | 1 | Converter 2 output channel C |
| cfg_c1_en | input | 1 | Converter 1 enable request |
| cfg_c1_line | input | 2 | Converter 1 data line request |
| cfg_c1_pair | input | 2 | Converter 1 clock pair request |
| cfg_c2_en | input | 1 | Converter 2 enable request |
| cfg_c2_line | input | 2 | Converter 2 data line request |
| cfg_c2_pair | input | 2 | Converter 2 clock pair request |
| cfg_sp_pair | input | 2 | Synchronous port clock pair request |
| cfg_swap_b | input | 1 | Replace line 2 with channel B |
| cfg_swap_c | input | 1 | Replace line 3 with channel C |
| c1_sdata | output | 1 | Data to converter 1 |
| c1_bclk | output | 1 | Bit clock to converter 1 |
| c1_lrclk | output | 1 | Frame clock to converter 1 |
| c2_sdata | output | 1 | Data to converter 2 |
| c2_bclk | output | 1 | Bit clock to converter 2 |
| c2_lrclk | output | 1 | Frame clock to converter 2 |
| sp_bclk | output | 1 | Synchronous port bit clock |
| sp_lrclk | output | 1 | Synchronous port frame clock |
| proc_data | output | 4 | Processor synchronous data lines |
| proc_valid | output | 4 | Per-line valid mask |
| proc_ch_a | output | 1 | Converter 2 channel A to processor |

## Verification
The hardest case to reach is the timing of a commit. A request must wait through frame edges on unrelated pairs. It must then land on exactly the first falling edge of its own active pair, or be dropped if it was withdrawn or invalid. The bench drives each frame clock as a separate level under direct control. It lowers one pair at a time, and checks the outputs both after a foreign pair falls and after the route's own pair falls. A model of the active settings, kept in the bench, predicts every routed and masked value.

// File: rtl/air_pkg.sv
package air_pkg;
    localparam int NUM_LINES   = 4;
    localparam int NUM_PAIRS   = 3;
    localparam int LINE_W      = $clog2(NUM_LINES);
    localparam int PAIR_W      = $clog2(NUM_PAIRS);
    localparam int SWAP_B_LINE = 2;
    localparam int SWAP_C_LINE = 3;

    typedef struct packed {
        logic              en;
        logic [LINE_W-1:0] line;
        logic [PAIR_W-1:0] pair;
    } conv_cfg_t;

    typedef struct packed {
        logic [PAIR_W-1:0] pair;
        logic              swap_b;
        logic              swap_c;
    } sync_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_COMMIT = 2'd2
    } commit_state_t;

    localparam conv_cfg_t CONV1_RST = '{en: 1'b0, line: '0, pair: PAIR_W'(0)};
    localparam conv_cfg_t CONV2_RST = '{en: 1'b0, line: '0, pair: PAIR_W'(2)};
    localparam sync_cfg_t SYNC_RST  = '{pair: PAIR_W'(1), swap_b: 1'b0, swap_c: 1'b0};
endpackage

// File: rtl/air_frame_edge.sv
module air_frame_edge #(
    parameter int PAIRS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAIRS-1:0] lrclk,
    output logic [PAIRS-1:0] fall
);
    logic [PAIRS-1:0] lr_q;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lr_q[p] <= 1'b0;
            else        lr_q[p] <= lrclk[p];
        end
        assign fall[p] = lr_q[p] & ~lrclk[p];

        // R9: a frame edge needs the frame clock high one cycle earlier
        a_r9_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
            fall[p] |-> $past(lrclk[p]));
    end
endmodule

// File: rtl/air_cfg_commit.sv
module air_cfg_commit
    import air_pkg::*;
#(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic         req_ok,
    input  logic         frame_tick,
    output logic [W-1:0] active
);
    commit_state_t st_q, st_d;
    logic          load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_ok && (req != active)) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!req_ok || (req == active)) begin
                    st_d = ST_IDLE;
                end else if (frame_tick) begin
                    st_d = ST_COMMIT;
                    load = 1'b1;
                end
            end
            ST_COMMIT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    active <= RST_VAL;
        else if (load) active <= req;
    end

    a_r9_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(active));
    a_r10_equal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req == active) |=> $stable(active));
    a_r11_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ok |=> $stable(active));
endmodule

// File: rtl/air_proc_lanes.sv
module air_proc_lanes
    import air_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] sdin,
    input  conv_cfg_t            c1_act,
    input  conv_cfg_t            c2_act,
    input  sync_cfg_t            sp_act,
    input  logic                 ch_a,
    input  logic                 ch_b,
    input  logic                 ch_c,
    output logic [NUM_LINES-1:0] proc_data,
    output logic [NUM_LINES-1:0] proc_valid,
    output logic                 proc_ch_a
);
    logic [NUM_LINES-1:0] claimed;
    logic [NUM_LINES-1:0] valid_d;
    logic [NUM_LINES-1:0] src_d;

    always_comb begin
        claimed = '0;
        if (c1_act.en) claimed[c1_act.line] = 1'b1;
        if (c2_act.en) claimed[c2_act.line] = 1'b1;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
        if (i == SWAP_B_LINE) begin : g_swb
            assign valid_d[i] = sp_act.swap_b | ~claimed[i];
            assign src_d[i]   = sp_act.swap_b ? ch_b : sdin[i];
            a_r6_swap_b_valid: assert property (@(posedge clk) disable iff (!rst_n)
                sp_act.swap_b |=> (proc_valid[i] && proc_data[i] == $past(ch_b)));
        end else if (i == SWAP_C_LINE) begin : g_swc
            assign valid_d[i] = sp_act.swap_c | ~claimed[i];
            assign src_d[i]   = sp_act.swap_c ? ch_c : sdin[i];
            a_r7_swap_c_valid: assert property (@(posedge clk) disable iff (!rst_n)
                sp_act.swap_c |=> (proc_valid[i] && proc_data[i] == $past(ch_c)));
        end else begin : g_plain
            assign valid_d[i] = ~claimed[i];
            assign src_d[i]   = sdin[i];
            a_r5_claim_masks: assert property (@(posedge clk) disable iff (!rst_n)
                ((c1_act.en && c1_act.line == LINE_W'(i)) || (c2_act.en && c2_act.line == LINE_W'(i)))
                |=> (!proc_valid[i] && !proc_data[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proc_data  <= '0;
            proc_valid <= '1;
            proc_ch_a  <= 1'b0;
        end else begin
            proc_data  <= src_d & valid_d;
            proc_valid <= valid_d;
            proc_ch_a  <= ch_a;
        end
    end

    a_r8_cha_pass: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (proc_ch_a == $past(ch_a)));
    a_r5_masked_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((proc_data & ~proc_valid) == '0));
endmodule

// File: rtl/audio_in_router.sv
module audio_in_router
    import air_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sdin,
    input  logic [2:0] bclk,
    input  logic [2:0] lrclk,
    input  logic       src_ch_a,
    input  logic       src_ch_b,
    input  logic       src_ch_c,
    input  logic       cfg_c1_en,
    input  logic [1:0] cfg_c1_line,
    input  logic [1:0] cfg_c1_pair,
    input  logic       cfg_c2_en,
    input  logic [1:0] cfg_c2_line,
    input  logic [1:0] cfg_c2_pair,
    input  logic [1:0] cfg_sp_pair,
    input  logic       cfg_swap_b,
    input  logic       cfg_swap_c,
    output logic       c1_sdata,
    output logic       c1_bclk,
    output logic       c1_lrclk,
    output logic       c2_sdata,
    output logic       c2_bclk,
    output logic       c2_lrclk,
    output logic       sp_bclk,
    output logic       sp_lrclk,
    output logic [3:0] proc_data,
    output logic [3:0] proc_valid,
    output logic       proc_ch_a
);
    localparam int CONV_W = $bits(conv_cfg_t);
    localparam int SYNC_W = $bits(sync_cfg_t);

    conv_cfg_t c1_req, c2_req, c1_act, c2_act;
    sync_cfg_t sp_req, sp_act;
    logic [NUM_PAIRS-1:0] fall;
    logic c1_ok, c2_ok, sp_ok;

    assign c1_req = '{en: cfg_c1_en, line: cfg_c1_line, pair: cfg_c1_pair};
    assign c2_req = '{en: cfg_c2_en, line: cfg_c2_line, pair: cfg_c2_pair};
    assign sp_req = '{pair: cfg_sp_pair, swap_b: cfg_swap_b, swap_c: cfg_swap_c};
    assign c1_ok  = (int'(cfg_c1_pair) < NUM_PAIRS);
    assign c2_ok  = (int'(cfg_c2_pair) < NUM_PAIRS);
    assign sp_ok  = (int'(cfg_sp_pair) < NUM_PAIRS);

    air_frame_edge #(.PAIRS(NUM_PAIRS)) u_edge (
        .clk(clk), .rst_n(rst_n), .lrclk(lrclk), .fall(fall)
    );

    air_cfg_commit #(.W(CONV_W), .RST_VAL(CONV1_RST)) u_c1_commit (
        .clk(clk), .rst_n(rst_n), .req(c1_req), .req_ok(c1_ok),
        .frame_tick(fall[c1_act.pair]), .active(c1_act)
    );

    air_cfg_commit #(.W(CONV_W), .RST_VAL(CONV2_RST)) u_c2_commit (
        .clk(clk), .rst_n(rst_n), .req(c2_req), .req_ok(c2_ok),
        .frame_tick(fall[c2_act.pair]), .active(c2_act)
    );

    air_cfg_commit #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sp_commit (
        .clk(clk), .rst_n(rst_n), .req(sp_req), .req_ok(sp_ok),
        .frame_tick(fall[sp_act.pair]), .active(sp_act)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_sdata <= 1'b0; c1_bclk <= 1'b0; c1_lrclk <= 1'b0;
            c2_sdata <= 1'b0; c2_bclk <= 1'b0; c2_lrclk <= 1'b0;
            sp_bclk  <= 1'b0; sp_lrclk <= 1'b0;
        end else begin
            c1_sdata <= sdin[c1_act.line];
            c1_bclk  <= bclk[c1_act.pair];
            c1_lrclk <= lrclk[c1_act.pair];
            c2_sdata <= sdin[c2_act.line];
            c2_bclk  <= bclk[c2_act.pair];
            c2_lrclk <= lrclk[c2_act.pair];
            sp_bclk  <= bclk[sp_act.pair];
            sp_lrclk <= lrclk[sp_act.pair];
        end
    end

    air_proc_lanes u_lanes (
        .clk(clk), .rst_n(rst_n), .sdin(sdin),
        .c1_act(c1_act), .c2_act(c2_act), .sp_act(sp_act),
        .ch_a(src_ch_a), .ch_b(src_ch_b), .ch_c(src_ch_c),
        .proc_data(proc_data), .proc_valid(proc_valid), .proc_ch_a(proc_ch_a)
    );

    a_r2_c1_route: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (c1_sdata == $past(sdin[c1_act.line]) && c1_lrclk == $past(lrclk[c1_act.pair])));
    a_r3_c2_route: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (c2_sdata == $past(sdin[c2_act.line]) && c2_bclk == $past(bclk[c2_act.pair])));
    a_r4_sp_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sp_bclk == $past(bclk[sp_act.pair]) && sp_lrclk == $past(lrclk[sp_act.pair])));
endmodule

// File: tb/audio_in_router_tb.sv
module audio_in_router_tb;
    import air_pkg::*;

    typedef struct packed {
        logic [2:0] c1;
        logic [2:0] c2;
        logic [1:0] sp;
        logic [3:0] data;
        logic [3:0] valid;
        logic       cha;
    } obs_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] sdin = 4'b0000;
    logic [2:0] bclk = 3'b000;
    logic [2:0] lrclk = 3'b111;
    logic ch_a = 1'b0, ch_b = 1'b0, ch_c = 1'b0;
    logic c1_en = 1'b0, c2_en = 1'b0, sw_b = 1'b0, sw_c = 1'b0;
    logic [1:0] c1_line = 2'd0, c1_pair = 2'd0, c2_line = 2'd0, c2_pair = 2'd2, sp_pair = 2'd1;

    logic c1_sdata, c1_bclk, c1_lrclk, c2_sdata, c2_bclk, c2_lrclk, sp_bclk, sp_lrclk, proc_ch_a;
    logic [3:0] proc_data, proc_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    conv_cfg_t m_c1 = CONV1_RST;
    conv_cfg_t m_c2 = CONV2_RST;
    sync_cfg_t m_sp = SYNC_RST;

    obs_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    audio_in_router u_dut (
        .clk(clk), .rst_n(rst_n), .sdin(sdin), .bclk(bclk), .lrclk(lrclk),
        .src_ch_a(ch_a), .src_ch_b(ch_b), .src_ch_c(ch_c),
        .cfg_c1_en(c1_en), .cfg_c1_line(c1_line), .cfg_c1_pair(c1_pair),
        .cfg_c2_en(c2_en), .cfg_c2_line(c2_line), .cfg_c2_pair(c2_pair),
        .cfg_sp_pair(sp_pair), .cfg_swap_b(sw_b), .cfg_swap_c(sw_c),
        .c1_sdata(c1_sdata), .c1_bclk(c1_bclk), .c1_lrclk(c1_lrclk),
        .c2_sdata(c2_sdata), .c2_bclk(c2_bclk), .c2_lrclk(c2_lrclk),
        .sp_bclk(sp_bclk), .sp_lrclk(sp_lrclk),
        .proc_data(proc_data), .proc_valid(proc_valid), .proc_ch_a(proc_ch_a)
    );

    function automatic obs_t predict();
        obs_t o;
        logic [3:0] claim = 4'b0000;
        logic [3:0] src = sdin;
        o.c1 = {sdin[m_c1.line], bclk[m_c1.pair], lrclk[m_c1.pair]};
        o.c2 = {sdin[m_c2.line], bclk[m_c2.pair], lrclk[m_c2.pair]};
        o.sp = {bclk[m_sp.pair], lrclk[m_sp.pair]};
        if (m_c1.en) claim[m_c1.line] = 1'b1;
        if (m_c2.en) claim[m_c2.line] = 1'b1;
        o.valid = ~claim;
        if (m_sp.swap_b) begin o.valid[2] = 1'b1; src[2] = ch_b; end
        if (m_sp.swap_c) begin o.valid[3] = 1'b1; src[3] = ch_c; end
        o.data = src & o.valid;
        o.cha = ch_a;
        return o;
    endfunction

    // monitor: pops expected items and compares with the ports
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            obs_t e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{c1: {c1_sdata, c1_bclk, c1_lrclk}, c2: {c2_sdata, c2_bclk, c2_lrclk},
                  sp: {sp_bclk, sp_lrclk}, data: proc_data, valid: proc_valid, cha: proc_ch_a};
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string tag);
        tick(2);
        exp_q.push_back(predict());
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    // frame boundary on pair p: model applies pending valid requests whose active pair is p
    task automatic frame(int p);
        conv_cfg_t r1, r2;
        sync_cfg_t rs;
        r1 = '{en: c1_en, line: c1_line, pair: c1_pair};
        r2 = '{en: c2_en, line: c2_line, pair: c2_pair};
        rs = '{pair: sp_pair, swap_b: sw_b, swap_c: sw_c};
        lrclk[p] = 1'b0;
        tick(2);
        if (c1_pair < 3 && int'(m_c1.pair) == p) m_c1 = r1;
        if (c2_pair < 3 && int'(m_c2.pair) == p) m_c2 = r2;
        if (sp_pair < 3 && int'(m_sp.pair) == p) m_sp = rs;
    endtask

    task automatic frame_end(int p);
        lrclk[p] = 1'b1;
        tick(2);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        sdin = 4'b1010; bclk = 3'b101;
        expect_now("R1 reset defaults");

        sdin = 4'b0110; bclk = 3'b010; ch_a = 1'b1;
        expect_now("R2 R3 R4 default routes pattern A");
        sdin = 4'b1001; bclk = 3'b100; ch_a = 1'b0;
        expect_now("R2 R3 R4 default routes pattern B");

        // R9: converter 1 request, foreign edge first
        c1_en = 1'b1; c1_line = 2'd1; c1_pair = 2'd1;
        tick(3);
        frame(2);
        expect_now("R9 foreign pair edge no commit");
        frame_end(2);
        frame(0);
        expect_now("R9 R2 R5 converter 1 commit on own edge");
        frame_end(0);
        sdin = 4'b0010; bclk = 3'b010;
        expect_now("R2 converter 1 new line and pair");

        // converter 2 on line 2, pair 0 (commits on pair 2)
        c2_en = 1'b1; c2_line = 2'd2; c2_pair = 2'd0;
        tick(3);
        frame(2);
        expect_now("R3 R5 converter 2 claims line 2");
        frame_end(2);
        sdin = 4'b1111; bclk = 3'b001;
        expect_now("R5 claimed lines read zero");

        // swaps and sync pair change (commit on pair 1)
        sw_b = 1'b1; sw_c = 1'b1; sp_pair = 2'd2; ch_b = 1'b1; ch_c = 1'b0;
        tick(3);
        frame(1);
        expect_now("R6 R7 R4 swaps committed");
        frame_end(1);
        ch_b = 1'b0; ch_c = 1'b1; bclk = 3'b100;
        expect_now("R6 R7 swapped channels follow source");

        // R10: cancel before edge (converter 1 active pair 1)
        c1_line = 2'd3;
        tick(3);
        c1_line = 2'd1;
        tick(3);
        frame(1);
        expect_now("R10 withdrawn request no change");
        frame_end(1);

        // R11: invalid pair code 3
        c1_line = 2'd0; c1_pair = 2'd3;
        tick(3);
        frame(1);
        expect_now("R11 invalid pair ignored");
        frame_end(1);
        c1_pair = 2'd1;

        // R8 channel A
        ch_a = 1'b1;
        expect_now("R8 channel A high");
        ch_a = 1'b0; sdin = 4'b0101;
        expect_now("R8 channel A low");

        tick(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule